// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit accumulator datapath. Each cycle it can take an accumulator value, a second operand (an immediate or a value read from a register file) and a 3-bit operation select. It computes one 8-bit result and five status flags: negative, signed overflow, carry, nibble carry and zero.

The result and the flags are captured in registers on the clock edge at which `op_valid` is high. When `op_valid` is low, both keep their values. The add-with-carry operation takes its carry-in from the stored carry flag, so multi-byte sums can be chained one byte per operation.

Flags are updated by operation class. Arithmetic operations (add, add with carry, decrement) write all five flags. Logic, move and complement operations write only negative and zero. The carry, overflow and nibble carry flags then keep the values left by the last arithmetic operation.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `result_q` becomes 0x00 and all five flag outputs become 0.
- R2: Operation code 0 (add) stores `(acc_in + opnd_in) mod 256`. `flag_cry` is the carry out of bit 7.
- R3: Operation code 1 (add with carry) stores `(acc_in + opnd_in + C) mod 256`, where C is the stored `flag_cry` value before the operation. `flag_cry` is the new carry out of bit 7.
- R4: For arithmetic operations, `flag_dcy` is the carry out of bit 3 into bit 4 of the same addition, including any carry-in.
- R5: For arithmetic operations, `flag_ovf` is 1 exactly when both addends have the same bit 7 and the result bit 7 differs from it.
- R6: After every issued operation, `flag_neg` equals bit 7 of the new result and `flag_zro` is 1 exactly when the new result is 0x00.
- R7: The non-arithmetic operations store the following results:
  - code 2: `~opnd_in`
  - code 4: `opnd_in`
  - code 5: `acc_in & opnd_in`
  - code 6: `acc_in | opnd_in`
  - code 7: `acc_in ^ opnd_in`
- R8: Operation codes 2, 4, 5, 6 and 7 leave `flag_cry`, `flag_ovf` and `flag_dcy` unchanged.
- R9: Operation code 3 (decrement) stores `opnd_in - 1` (mod 256). Its flags are those of the addition `opnd_in + 0xFF` with no carry-in:
  - `flag_cry` = 1 when `opnd_in` is not 0x00 (no borrow)
  - `flag_dcy` = 1 when the low nibble of `opnd_in` is not 0
  - `flag_ovf` = 1 only for `opnd_in` = 0x80
- R10: A rising edge with `op_valid` low leaves `result_q` and all five flags unchanged.
- R11: An operation issued at one rising edge appears on `result_q` and the flags right after that edge. There is exactly one register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Issue the operation presented this cycle |
| op_code | input | 3 | Operation select (0 add, 1 add with carry, 2 complement, 3 decrement, 4 move, 5 and, 6 or, 7 xor) |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand (immediate or register value) |
| result_q | output | 8 | Registered result |
| flag_neg | output | 1 | Negative flag |
| flag_ovf | output | 1 | Signed overflow flag |
| flag_cry | output | 1 | Carry / no-borrow flag |
| flag_dcy | output | 1 | Carry out of bit 3 |
| flag_zro | output | 1 | Zero flag |

## Verification
Every result and every flag is due one rising edge after the edge that samples `op_valid` high. The bench therefore drives the operands and the operation on a falling edge and compares all six outputs on the next falling edge. That is half a period after the capturing edge and before any later edge.

A hold check for an idle edge (R10) is made on that same falling edge. The expected flags are carried forward in the bench model from one operation to the next. This lets the stored carry feeding add-with-carry, and the flags that logic operations keep, be predicted without looking inside the design.

// File: rtl/alu_pkg.sv
// Shared definitions for the accumulator ALU.
// Assumes a 3-bit operation select that covers all eight codes.
package alu_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDC = 3'd1,
        OP_COMP = 3'd2,
        OP_DEC  = 3'd3,
        OP_MOVE = 3'd4,
        OP_AND  = 3'd5,
        OP_OR   = 3'd6,
        OP_XOR  = 3'd7
    } op_e;

    typedef struct packed {
        logic neg;
        logic ovf;
        logic cry;
        logic dcy;
        logic zro;
    } flags_t;

    // True for the operations that write all five flags.
    function automatic logic op_is_arith(input op_e op);
        return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_DEC);
    endfunction

endpackage

// File: rtl/alu_adder.sv
// Carry-in adder that also reports the nibble carry and signed overflow.
// Assumes 0 < NIB < WIDTH. The nibble carry is the carry out of bit NIB-1.
module alu_adder #(
    parameter int WIDTH = 8,
    parameter int NIB   = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             c_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             dcout_o,
    output logic             ovf_o
);
    localparam int LO_W = NIB + 1;
    localparam int FULL_W = WIDTH + 1;

    logic [FULL_W-1:0] full_sum;
    logic [LO_W-1:0]   lo_sum;

    // Full-width and low-segment sums with the shared carry-in.
    always_comb begin
        full_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, c_i};
        lo_sum   = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + {{NIB{1'b0}}, c_i};
    end

    // Unpack the sums into the result and the three carry-type flags.
    always_comb begin
        sum_o   = full_sum[WIDTH-1:0];
        cout_o  = full_sum[WIDTH];
        dcout_o = lo_sum[NIB];
        ovf_o   = (a_i[WIDTH-1] == b_i[WIDTH-1]) && (full_sum[WIDTH-1] != a_i[WIDTH-1]);
    end
endmodule

// File: rtl/alu_logic.sv
// Bitwise unit: complement, move, and, or, xor.
// Assumes the arithmetic codes never select this output (it returns the operand for them).
module alu_logic #(
    parameter int WIDTH = 8
) (
    input  alu_pkg::op_e     op_i,
    input  logic [WIDTH-1:0] acc_i,
    input  logic [WIDTH-1:0] opnd_i,
    output logic [WIDTH-1:0] res_o
);
    import alu_pkg::*;

    // Select the bitwise function named by the operation code.
    always_comb begin
        case (op_i)
            OP_COMP: res_o = ~opnd_i;
            OP_AND:  res_o = acc_i & opnd_i;
            OP_OR:   res_o = acc_i | opnd_i;
            OP_XOR:  res_o = acc_i ^ opnd_i;
            default: res_o = opnd_i;
        endcase
    end
endmodule

// File: rtl/alu_flags.sv
// Status flag register with class-based update.
// Negative and zero are derived from the new result on every issued operation.
// Carry, overflow and nibble carry change only when arith_i is high.
// Synchronous active-low reset clears all flags.
module alu_flags #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_i,
    input  logic             arith_i,
    input  logic [WIDTH-1:0] res_i,
    input  logic             cry_i,
    input  logic             dcy_i,
    input  logic             ovf_i,
    output alu_pkg::flags_t  flags_o
);
    import alu_pkg::*;

    flags_t flg_q;
    flags_t flg_nxt;

    // Build the next flag word, keeping carry-type flags for non-arithmetic ops.
    always_comb begin
        flg_nxt     = flg_q;
        flg_nxt.neg = res_i[WIDTH-1];
        flg_nxt.zro = (res_i == '0);
        if (arith_i) begin
            flg_nxt.cry = cry_i;
            flg_nxt.dcy = dcy_i;
            flg_nxt.ovf = ovf_i;
        end
    end

    // Flag storage: clear on reset, load on an issued operation, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= '0;
        end else if (upd_i) begin
            flg_q <= flg_nxt;
        end
    end

    assign flags_o = flg_q;
endmodule

// File: rtl/acc_alu.sv
// Top of the accumulator ALU.
// Routes the operands into a shared adder (add, add with carry, decrement)
// or the bitwise unit. It then registers the result and the flags when op_valid is high.
// Assumes op_code is meaningful only in cycles where op_valid is high.
module acc_alu #(
    parameter int WIDTH = alu_pkg::DATA_W,
    parameter int NIB   = WIDTH / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [2:0]       op_code,
    input  logic [WIDTH-1:0] acc_in,
    input  logic [WIDTH-1:0] opnd_in,
    output logic [WIDTH-1:0] result_q,
    output logic             flag_neg,
    output logic             flag_ovf,
    output logic             flag_cry,
    output logic             flag_dcy,
    output logic             flag_zro
);
    import alu_pkg::*;

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    op_e              op;
    logic             is_arith;
    logic [WIDTH-1:0] add_a;
    logic [WIDTH-1:0] add_b;
    logic             add_ci;
    logic [WIDTH-1:0] add_sum;
    logic             add_co;
    logic             add_dc;
    logic             add_ov;
    logic [WIDTH-1:0] log_res;
    logic [WIDTH-1:0] res_nxt;
    logic [WIDTH-1:0] res_q;
    flags_t           flg;

    assign op       = op_e'(op_code);
    assign is_arith = op_is_arith(op);

    // Adder operand steering: decrement adds all-ones to the operand.
    always_comb begin
        add_a  = acc_in;
        add_b  = opnd_in;
        add_ci = 1'b0;
        case (op)
            OP_ADDC: add_ci = flg.cry;
            OP_DEC: begin
                add_a = opnd_in;
                add_b = ALL_ONES;
            end
            default: ;
        endcase
    end

    alu_adder #(.WIDTH(WIDTH), .NIB(NIB)) u_adder (
        .a_i     (add_a),
        .b_i     (add_b),
        .c_i     (add_ci),
        .sum_o   (add_sum),
        .cout_o  (add_co),
        .dcout_o (add_dc),
        .ovf_o   (add_ov)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .op_i   (op),
        .acc_i  (acc_in),
        .opnd_i (opnd_in),
        .res_o  (log_res)
    );

    // Pick the arithmetic or bitwise result.
    always_comb begin
        res_nxt = is_arith ? add_sum : log_res;
    end

    // Result register: clear on reset, load on an issued operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (op_valid) begin
            res_q <= res_nxt;
        end
    end

    alu_flags #(.WIDTH(WIDTH)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_i   (op_valid),
        .arith_i (is_arith),
        .res_i   (res_nxt),
        .cry_i   (add_co),
        .dcy_i   (add_dc),
        .ovf_i   (add_ov),
        .flags_o (flg)
    );

    assign result_q = res_q;
    assign flag_neg = flg.neg;
    assign flag_ovf = flg.ovf;
    assign flag_cry = flg.cry;
    assign flag_dcy = flg.dcy;
    assign flag_zro = flg.zro;
endmodule

// File: rtl/acc_alu_chk.sv
// Port-level property checker for acc_alu, attached with bind.
module acc_alu_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [2:0]       op_code,
    input logic [WIDTH-1:0] acc_in,
    input logic [WIDTH-1:0] opnd_in,
    input logic [WIDTH-1:0] result_q,
    input logic             flag_neg,
    input logic             flag_ovf,
    input logic             flag_cry,
    input logic             flag_dcy,
    input logic             flag_zro
);
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(op_valid)) |->
        ($stable(result_q) && $stable(flag_neg) && $stable(flag_ovf) &&
         $stable(flag_cry) && $stable(flag_dcy) && $stable(flag_zro)));

    // R6
    neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_valid)) |->
        ((flag_zro == (result_q == '0)) && (flag_neg == result_q[WIDTH-1])));

    // R8
    keep_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_valid) &&
         ($past(op_code) != 3'd0) && ($past(op_code) != 3'd1) && ($past(op_code) != 3'd3)) |->
        ($stable(flag_cry) && $stable(flag_ovf) && $stable(flag_dcy)));

    // R9
    dec_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_valid) && ($past(op_code) == 3'd3)) |->
        ((flag_cry == ($past(opnd_in) != '0)) && (result_q == $past(opnd_in) - 1'b1)));

    // R2
    add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_valid) && ($past(op_code) == 3'd0)) |->
        (result_q == WIDTH'($past(acc_in) + $past(opnd_in))));
endmodule

bind acc_alu acc_alu_chk #(.WIDTH(WIDTH)) u_acc_alu_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .acc_in   (acc_in),
    .opnd_in  (opnd_in),
    .result_q (result_q),
    .flag_neg (flag_neg),
    .flag_ovf (flag_ovf),
    .flag_cry (flag_cry),
    .flag_dcy (flag_dcy),
    .flag_zro (flag_zro)
);

// File: tb/test_acc_alu.sv
module test_acc_alu;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [2:0] op_code = 3'd0;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] opnd_in = 8'h00;
    logic [7:0] result_q;
    logic       flag_neg, flag_ovf, flag_cry, flag_dcy, flag_zro;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Expected state: result and flags {neg, ovf, cry, dcy, zro}.
    logic [7:0] exp_res = 8'h00;
    logic [4:0] exp_flg = 5'b0;

    always #5 clk = ~clk;

    acc_alu i_acc_alu (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .acc_in(acc_in), .opnd_in(opnd_in), .result_q(result_q),
        .flag_neg(flag_neg), .flag_ovf(flag_ovf), .flag_cry(flag_cry),
        .flag_dcy(flag_dcy), .flag_zro(flag_zro)
    );

    // Reference model: returns {result, neg, ovf, cry, dcy, zro}.
    function automatic logic [12:0] model(input logic [2:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic [4:0] fl);
        logic [7:0] x, y, r;
        logic       ci, arith, ov, co, dc;
        logic [8:0] s9;
        logic [4:0] lo;
        x = a; y = b; ci = 1'b0; arith = 1'b1; r = 8'h00;
        case (op)
            3'd0: ;
            3'd1: ci = fl[2];
            3'd3: begin x = b; y = 8'hFF; end
            default: arith = 1'b0;
        endcase
        s9 = {1'b0, x} + {1'b0, y} + {8'h00, ci};
        lo = {1'b0, x[3:0]} + {1'b0, y[3:0]} + {4'h0, ci};
        co = s9[8];
        dc = lo[4];
        ov = (x[7] == y[7]) && (s9[7] != x[7]);
        case (op)
            3'd2: r = ~b;
            3'd4: r = b;
            3'd5: r = a & b;
            3'd6: r = a | b;
            3'd7: r = a ^ b;
            default: r = s9[7:0];
        endcase
        if (!arith) begin
            ov = fl[3]; co = fl[2]; dc = fl[1];
        end
        return {r, r[7], ov, co, dc, (r == 8'h00)};
    endfunction

    task automatic check(input string tag);
        logic [12:0] act, exp;
        act = {result_q, flag_neg, flag_ovf, flag_cry, flag_dcy, flag_zro};
        exp = {exp_res, exp_flg};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual res=%h flags=%b expected res=%h flags=%b",
                     tag, act[12:5], act[4:0], exp[12:5], exp[4:0]);
        end
    endtask

    // Drive one operation on a falling edge, compare on the next falling edge.
    task automatic do_op(input logic v, input logic [2:0] op, input logic [7:0] a,
                         input logic [7:0] b, input string tag);
        logic [12:0] m;
        op_valid = v; op_code = op; acc_in = a; opnd_in = b;
        if (v) begin
            m = model(op, a, b, exp_flg);
            exp_res = m[12:5];
            exp_flg = m[4:0];
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd24680));
        // R1: reset clears the result and flags even with an operation presented.
        op_valid = 1'b1; op_code = 3'd4; opnd_in = 8'hA5;
        repeat (3) @(negedge clk);
        exp_res = 8'h00; exp_flg = 5'b0;
        check("R1");
        rst_n = 1'b1;
        op_valid = 1'b0;
        @(negedge clk);
        check("R1 idle");

        // R11: result is visible one edge after issue.
        do_op(1'b1, 3'd4, 8'h00, 8'h3C, "R11 move");
        // R2: plain add with carry out and zero result.
        do_op(1'b1, 3'd0, 8'hFF, 8'h01, "R2 wrap");
        do_op(1'b1, 3'd0, 8'h12, 8'h34, "R2 small");
        // R4: carry from bit 3 only.
        do_op(1'b1, 3'd0, 8'h0F, 8'h01, "R4 nibble");
        // R5: positive overflow and negative overflow.
        do_op(1'b1, 3'd0, 8'h7F, 8'h01, "R5 pos");
        do_op(1'b1, 3'd0, 8'h80, 8'h80, "R5 neg");
        // R3: stored carry (set by previous op) enters the add.
        do_op(1'b1, 3'd1, 8'h10, 8'h20, "R3 cin1");
        do_op(1'b1, 3'd1, 8'h0F, 8'h00, "R3 cin0");
        // R8: logic op after an op that set carry keeps C/OV/DC.
        do_op(1'b1, 3'd0, 8'hFF, 8'hFF, "R2 setc");
        do_op(1'b1, 3'd5, 8'hF0, 8'h0F, "R8 and");
        do_op(1'b1, 3'd2, 8'h00, 8'h00, "R7 comp");
        do_op(1'b1, 3'd7, 8'hAA, 8'hAA, "R7 xor");
        do_op(1'b1, 3'd6, 8'h81, 8'h02, "R6 or");
        // R9: decrement corners.
        do_op(1'b1, 3'd3, 8'h55, 8'h00, "R9 zero");
        do_op(1'b1, 3'd3, 8'h55, 8'h80, "R9 ovf");
        do_op(1'b1, 3'd3, 8'h55, 8'h01, "R9 one");
        do_op(1'b1, 3'd3, 8'h55, 8'h10, "R9 nib");
        // R10: idle edges hold state whatever the inputs are.
        do_op(1'b0, 3'd0, 8'hFF, 8'hFF, "R10 idle");
        do_op(1'b0, 3'd2, 8'h00, 8'h00, "R10 idle2");

        // R6: random mix of all operations, some idle.
        for (int i = 0; i < 400; i++) begin
            do_op(($urandom % 8) != 0, 3'($urandom), 8'($urandom), 8'($urandom), "R6 rand");
        end

        finish_run();
    end
endmodule